// File: doc/BRIEF.md
# Toggle-Handshake Dual-Edge RAM

This block pairs a small datapath-side requester with a single-port RAM array. They share one clock but use opposite edges. On a rising edge the requester accepts a command by inverting its request flag. At the same edge it registers the command's address, its write enable and its write data. The RAM works on the falling edge. It acts only while its own enable flag disagrees with the request flag. When it acts it performs the store or the load and then copies the request flag, which makes it idle again.

Because the RAM is clocked on the opposite edge, every access completes inside one clock period. A store is in the array before the next rising edge. A load result sits in the RAM's data-out register and is copied into the requester's destination register on the next rising edge, together with a one-cycle valid pulse. A new command can be issued on every rising edge.

The array depth need not be a power of two. Addresses at or above the depth are treated as absent: a store to one is dropped, and a load from one returns zero.

Top module: `toggle_ram`

## Requirements
- R1: When `cmd_go` is high at a rising edge, `req_flag` inverts at that edge, and `cmd_we`, `cmd_addr` and `cmd_wdata` are captured as the pending command. When `cmd_go` is low, `req_flag` keeps its value.
- R2: The RAM serves a request at the first falling edge after `req_flag` and `en_flag` start to differ, then sets `en_flag` equal to `req_flag`. The two flags are therefore equal after every falling edge.
- R3: A store (`cmd_we` = 1) writes the data into the array at its falling edge. A load of the same address issued at the very next rising edge returns the stored word.
- R4: A load (`cmd_we` = 0) puts the addressed word in `rd_data` at its falling edge. On the following rising edge `dest_q` takes that value and `dest_vld` is high for exactly that cycle.
- R5: With no request pending, neither the array nor `rd_data` changes, whatever the values on `cmd_we`, `cmd_addr` and `cmd_wdata`.
- R6: While `rst_n` is low, `req_flag`, `en_flag`, `rd_data`, `dest_q` and `dest_vld` are all 0, so no access is pending when reset ends.
- R7: An address at or above DEPTH (24 by default) selects no word. A store to it leaves every word unchanged, and a load from it returns 0.
- R8: Commands issued on consecutive rising edges are each served, and each load delivers its own word in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the requester uses the rising edge, the RAM the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | Issue a command at this rising edge |
| cmd_we | input | 1 | 1 = store, 0 = load |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Store data |
| req_flag | output | 1 | Requester's toggle flag |
| en_flag | output | 1 | RAM's enable flag, which follows `req_flag` once served |
| rd_data | output | DATA_W | RAM data-out register |
| dest_q | output | DATA_W | Destination register holding the last load result |
| dest_vld | output | 1 | High for the cycle in which `dest_q` took a new load result |

## Verification
The checker watches several rules on every rising edge: the flags agree, the request flag toggles exactly when a command is issued, `rd_data` stays still when no command was issued, and every load produces a `dest_vld` pulse that carries the data-out value seen one edge earlier. Other behaviour depends on the array's contents and can only be shown by the bench's scenarios, which compare against a shadow array. These are: a store followed at once by a load of the same word, long back-to-back load runs, idle cycles that wiggle the command inputs, and out-of-range stores that must not alias onto real words.

// File: rtl/toggle_ram.sv
module toggle_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 24,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              req_flag,
  output logic              en_flag,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dest_q,
  output logic              dest_vld
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              we_q, load_pend;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  wire hit    = {1'b0, addr_q} < LIMIT;
  wire active = en_flag != req_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_flag  <= 1'b0;
      we_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      load_pend <= 1'b0;
      dest_q    <= '0;
      dest_vld  <= 1'b0;
    end else begin
      dest_vld  <= load_pend;
      if (load_pend) dest_q <= rd_data;
      load_pend <= cmd_go && !cmd_we;
      if (cmd_go) begin
        req_flag <= ~req_flag;
        we_q     <= cmd_we;
        addr_q   <= cmd_addr;
        wdata_q  <= cmd_wdata;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_flag <= 1'b0;
      rd_data <= '0;
    end else if (active) begin
      en_flag <= req_flag;
      if (!we_q) rd_data <= hit ? mem[addr_q] : '0;
    end
  end

  always_ff @(negedge clk) begin
    if (rst_n && active && we_q && hit) mem[addr_q] <= wdata_q;
  end
endmodule

// File: rtl/toggle_ram_chk.sv
module toggle_ram_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_go,
  input logic              cmd_we,
  input logic              req_flag,
  input logic              en_flag,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] dest_q,
  input logic              dest_vld
);
  p_reset_clear_r6: assert property (@(posedge clk)
    !rst_n |-> (!req_flag && !en_flag && !dest_vld && rd_data == '0 && dest_q == '0));

  p_toggle_on_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> req_flag != $past(req_flag));

  p_hold_no_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_go |=> req_flag == $past(req_flag));

  p_flags_meet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_flag == req_flag);

  p_quiet_dout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_go |=> $stable(rd_data));

  p_load_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !cmd_we) |=> ##1 dest_vld);

  p_dest_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dest_vld |-> dest_q == $past(rd_data));
endmodule

bind toggle_ram toggle_ram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_we(cmd_we),
  .req_flag(req_flag), .en_flag(en_flag), .rd_data(rd_data),
  .dest_q(dest_q), .dest_vld(dest_vld)
);

// File: tb/sim_toggle_ram.sv
`timescale 1ns/1ps
module sim_toggle_ram;
  localparam int DW = 16;
  localparam int DEPTH = 24;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic req_flag, en_flag, dest_vld;
  logic [DW-1:0] rd_data, dest_q;

  int checks = 0, fails = 0;
  int shadow [DEPTH];
  bit prev_load = 0;
  int prev_exp = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  toggle_ram #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_go(go), .cmd_we(we), .cmd_addr(addr),
    .cmd_wdata(wdata), .req_flag(req_flag), .en_flag(en_flag),
    .rd_data(rd_data), .dest_q(dest_q), .dest_vld(dest_vld));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic step(input bit g, input bit w, input int a, input int d);
    logic old_req;
    logic [DW-1:0] old_rd;
    int exp;
    go = g; we = w; addr = AW'(a); wdata = DW'(d);
    old_req = req_flag;
    old_rd = rd_data;
    exp = 0;
    @(posedge clk); #1;
    chk(req_flag == (old_req ^ g), "R1 toggle", req_flag, old_req ^ g);
    if (prev_load) begin
      chk(dest_vld == 1'b1, "R4 dest_vld", dest_vld, 1);
      chk(dest_q == DW'(prev_exp), "R4/R8 dest_q", dest_q, prev_exp);
    end else
      chk(dest_vld == 1'b0, "R4 no pulse", dest_vld, 0);
    if (g && w && a < DEPTH) shadow[a] = d & 16'hFFFF;
    if (g && !w) exp = (a < DEPTH) ? shadow[a] : 0;
    go = 1'b0;
    @(negedge clk); #1;
    chk(en_flag == req_flag, "R2 flags equal", en_flag, req_flag);
    if (g && !w) chk(rd_data == DW'(exp), "R4/R3/R7 rd_data", rd_data, exp);
    if (!g) chk(rd_data == old_rd, "R5 rd_data still", rd_data, old_rd);
    prev_load = g && !w;
    prev_exp = exp;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #12;
    // R6: reset state
    chk(req_flag == 0, "R6 req_flag", req_flag, 0);
    chk(en_flag == 0, "R6 en_flag", en_flag, 0);
    chk(rd_data == 0, "R6 rd_data", rd_data, 0);
    chk(dest_q == 0, "R6 dest_q", dest_q, 0);
    chk(dest_vld == 0, "R6 dest_vld", dest_vld, 0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R3: fill the array
    for (int i = 0; i < DEPTH; i++) step(1, 1, i, 16'h1000 + i * 7);
    // R8: back-to-back loads
    for (int i = 0; i < DEPTH; i++) step(1, 0, i, 0);
    for (int i = DEPTH - 1; i >= 0; i -= 3) step(1, 0, i, 16'hAAAA);
    // R3: store then immediate load
    step(1, 1, 5, 16'h5A5A);
    step(1, 0, 5, 0);
    step(1, 1, 0, 16'hFFFF);
    step(1, 0, 0, 0);
    // R5: idle with wiggling inputs
    step(0, 1, 5, 16'hDEAD);
    step(0, 0, 9, 16'hBEEF);
    step(0, 1, 5, 16'h0001);
    step(1, 0, 5, 0);
    step(1, 0, 9, 0);
    // R7: out of range
    step(1, 1, 27, 16'hBEEF);
    step(1, 0, 27, 0);
    step(1, 1, 31, 16'h1234);
    step(1, 0, 31, 0);
    for (int i = 0; i < DEPTH; i++) step(1, 0, i, 0);
    // mixed stream
    for (int i = 0; i < 40; i++) step(i % 5 != 4, i % 3 == 0, (i * 11) % 32, i * 97);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule